// File: doc/BRIEF.md
# Two-Tier Round-Robin Output Arbiter

This block picks which of several queues feeding one output is served in a given cycle, one cycle being one time slot. Each queue reports two bits: whether it holds anything and whether the entry at its head is urgent. The queue logic keeps that urgency bit current and rewrites it every time an entry leaves the queue. The arbiter returns a one-hot grant and a valid flag. The grant is decided combinationally from the present inputs, and the round-robin state moves on at the clock edge that ends the slot.

Arbitration has two tiers. A queue belongs to the urgent tier when it is non-empty and its head bit is set. It belongs to the background tier when it is non-empty and its head bit is clear. An empty queue belongs to neither tier. The urgent tier always wins. The background tier is served only in a cycle in which no queue is in the urgent tier.

Each tier keeps its own rotating start pointer. After a tier grants queue i, its next search begins at (i+1) mod N. The pointer of a tier moves only when that tier issues the grant.

Top module: `prio_out_arbiter`

## Requirements
- R1: `grant` has at most one bit set in every cycle.
- R2: `grant_valid` is 1 exactly when at least one bit of `q_nonempty` is 1; when it is 0, `grant` is all zeros.
- R3: A queue whose `q_nonempty` bit is 0 is never granted, whatever the value of its `q_head_hi` bit.
- R4: When some queue has both `q_nonempty` and `q_head_hi` set to 1, the grant goes to one of those queues.
- R5: A queue whose head bit is 0 is granted only in a cycle in which no non-empty queue has its head bit set to 1.
- R6: Within the urgent tier, after queue i is granted, the next urgent grant goes to the first urgent-tier queue found searching upward from index (i+1) mod N, with wrap-around.
- R7: The background tier follows the same rotation as R6, using its own pointer.
- R8: A tier's pointer is unchanged by cycles in which the other tier issues the grant, and by cycles with no grant.
- R9: After reset, both pointers are 0, so the first grant in each tier goes to the lowest-index queue of that tier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slot clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| q_nonempty | input | N_QUEUES | Bit i is 1 when queue i holds at least one entry |
| q_head_hi | input | N_QUEUES | Bit i is 1 when the head entry of queue i is urgent |
| grant | output | N_QUEUES | One-hot selection of the queue served this slot |
| grant_valid | output | 1 | 1 when `grant` selects a queue |

## Verification
Some properties hold in every cycle and are checked by assertions each cycle. These are the one-hot grant, the match between the valid flag and the occupancy vector, the rule that an empty queue is never served, the rule that the urgent tier always wins, and the rule that an idle tier keeps its pointer. Rotation order cannot be judged from a single cycle. The same holds for how the two pointers stay independent across alternating tiers and for the return to index 0 after reset. Those are shown only by the bench's scripted slot sequences, which compare each grant against values worked out by hand.

// File: rtl/prio_arb_pkg.sv
package prio_arb_pkg;
   typedef enum logic [1:0] {
      TIER_IDLE = 2'd0,
      TIER_URG  = 2'd1,
      TIER_BKG  = 2'd2
   } tier_e;

   localparam int PICK_SCAN = 0;
   localparam int PICK_MASK = 1;
endpackage

// File: rtl/rr_pick.sv
module rr_pick #(
   parameter int N_REQ     = 4,
   parameter int PICK_IMPL = 0,
   localparam int IDX_W    = (N_REQ > 1) ? $clog2(N_REQ) : 1
) (
   input  logic [N_REQ-1:0] req,
   input  logic [IDX_W-1:0] start,
   output logic [N_REQ-1:0] gnt,
   output logic [IDX_W-1:0] gnt_idx,
   output logic             any
);
   import prio_arb_pkg::*;

   assign any = |req;

   generate
      if (PICK_IMPL == PICK_SCAN) begin : g_scan
         always_comb begin
            logic found;
            int   pos;
            found   = 1'b0;
            gnt     = '0;
            gnt_idx = '0;
            for (int k = 0; k < N_REQ; k++) begin
               pos = (int'(start) + k) % N_REQ;
               if (!found && req[pos]) begin
                  found        = 1'b1;
                  gnt[pos]     = 1'b1;
                  gnt_idx      = IDX_W'(pos);
               end
            end
         end
      end else begin : g_mask
         logic [N_REQ-1:0] upper_mask;
         logic [N_REQ-1:0] upper_req;
         logic [N_REQ-1:0] src;

         always_comb begin
            for (int i = 0; i < N_REQ; i++)
               upper_mask[i] = (i >= int'(start));
         end

         assign upper_req = req & upper_mask;
         assign src       = (|upper_req) ? upper_req : req;

         always_comb begin
            logic found;
            found   = 1'b0;
            gnt     = '0;
            gnt_idx = '0;
            for (int i = 0; i < N_REQ; i++) begin
               if (!found && src[i]) begin
                  found   = 1'b1;
                  gnt[i]  = 1'b1;
                  gnt_idx = IDX_W'(i);
               end
            end
         end
      end
   endgenerate

   always_comb begin
      a_r1_pick_onehot: assert ($onehot0(gnt));
   end
endmodule

// File: rtl/rr_tier.sv
module rr_tier #(
   parameter int N_REQ     = 4,
   parameter int PICK_IMPL = 0,
   localparam int IDX_W    = (N_REQ > 1) ? $clog2(N_REQ) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N_REQ-1:0] req,
   input  logic             win,
   output logic [N_REQ-1:0] gnt,
   output logic             any
);
   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(N_REQ - 1);

   logic [IDX_W-1:0] ptr_q;
   logic [IDX_W-1:0] sel_idx;
   logic             advance;

   rr_pick #(
      .N_REQ    (N_REQ),
      .PICK_IMPL(PICK_IMPL)
   ) u_pick (
      .req    (req),
      .start  (ptr_q),
      .gnt    (gnt),
      .gnt_idx(sel_idx),
      .any    (any)
   );

   assign advance = win & any;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         ptr_q <= '0;
      else if (advance)
         ptr_q <= (sel_idx == LAST_IDX) ? '0 : sel_idx + 1'b1;
   end

   a_r8_ptr_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !advance |=> $stable(ptr_q));
endmodule

// File: rtl/prio_out_arbiter.sv
module prio_out_arbiter #(
   parameter int N_QUEUES  = 4,
   parameter int PICK_IMPL = 0
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [N_QUEUES-1:0] q_nonempty,
   input  logic [N_QUEUES-1:0] q_head_hi,
   output logic [N_QUEUES-1:0] grant,
   output logic                grant_valid
);
   import prio_arb_pkg::*;

   generate
      if (N_QUEUES < 2) begin : g_bad_n
         $error("prio_out_arbiter: N_QUEUES must be at least 2");
      end
      if (PICK_IMPL != PICK_SCAN && PICK_IMPL != PICK_MASK) begin : g_bad_impl
         $error("prio_out_arbiter: PICK_IMPL must select scan or mask");
      end
   endgenerate

   logic [N_QUEUES-1:0] urg_req, bkg_req;
   logic [N_QUEUES-1:0] urg_gnt, bkg_gnt;
   logic                urg_any, bkg_any;
   tier_e               tier;

   assign urg_req = q_nonempty & q_head_hi;
   assign bkg_req = q_nonempty & ~q_head_hi;

   rr_tier #(.N_REQ(N_QUEUES), .PICK_IMPL(PICK_IMPL)) u_urg (
      .clk  (clk),
      .rst_n(rst_n),
      .req  (urg_req),
      .win  (1'b1),
      .gnt  (urg_gnt),
      .any  (urg_any)
   );

   rr_tier #(.N_REQ(N_QUEUES), .PICK_IMPL(PICK_IMPL)) u_bkg (
      .clk  (clk),
      .rst_n(rst_n),
      .req  (bkg_req),
      .win  (~urg_any),
      .gnt  (bkg_gnt),
      .any  (bkg_any)
   );

   always_comb begin
      if (urg_any)      tier = TIER_URG;
      else if (bkg_any) tier = TIER_BKG;
      else              tier = TIER_IDLE;
   end

   always_comb begin
      unique case (tier)
         TIER_URG: grant = urg_gnt;
         TIER_BKG: grant = bkg_gnt;
         default:  grant = '0;
      endcase
   end

   assign grant_valid = (tier != TIER_IDLE);

   a_r1_onehot: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(grant));
   a_r2_valid_match: assert property (@(posedge clk) disable iff (!rst_n)
      (grant_valid == (|q_nonempty)) && (grant_valid == (|grant)));
   a_r3_no_empty_grant: assert property (@(posedge clk) disable iff (!rst_n)
      (grant & ~q_nonempty) == '0);
   a_r4_urgent_first: assert property (@(posedge clk) disable iff (!rst_n)
      (|(q_nonempty & q_head_hi)) |-> (|(grant & q_head_hi)));
   a_r5_bkg_only_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (|(grant & ~q_head_hi)) |-> ((q_nonempty & q_head_hi) == '0));
endmodule

// File: tb/sim_prio_out_arbiter.sv
module sim_prio_out_arbiter;
   localparam int CLK_PERIOD = 10;
   localparam int N          = 4;
   localparam int N_ROWS     = 12;

   // each row: {q_nonempty, q_head_hi, expected grant}
   localparam logic [11:0] VEC [N_ROWS] = '{
      {4'b0000, 4'b0000, 4'b0000},  // R2 idle, no grant
      {4'b1111, 4'b0000, 4'b0001},  // R9 R7 background from 0
      {4'b1111, 4'b0000, 4'b0010},  // R7 rotate to 1
      {4'b1111, 4'b1010, 4'b0010},  // R4 R9 urgent first at 1
      {4'b1111, 4'b1010, 4'b1000},  // R6 rotate to 3
      {4'b1111, 4'b1010, 4'b0010},  // R6 wrap to 1
      {4'b1111, 4'b0000, 4'b0100},  // R8 background resumes at 2
      {4'b0110, 4'b1001, 4'b0010},  // R3 R5 urgent bits on empty queues ignored
      {4'b1011, 4'b0000, 4'b1000},  // R7 skip empty 2
      {4'b0001, 4'b0001, 4'b0001},  // R6 search 2,3 then 0
      {4'b1000, 4'b0000, 4'b1000},  // R7 lone background queue
      {4'b1100, 4'b0100, 4'b0100}   // R6 R8 urgent pointer at 1 picks 2
   };

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [N-1:0] q_nonempty = '0;
   logic [N-1:0] q_head_hi = '0;
   logic [N-1:0] grant;
   logic         grant_valid;
   int           n_checks = 0;
   int           n_fail = 0;
   bit           done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   prio_out_arbiter #(.N_QUEUES(N)) u0 (
      .clk        (clk),
      .rst_n      (rst_n),
      .q_nonempty (q_nonempty),
      .q_head_hi  (q_head_hi),
      .grant      (grant),
      .grant_valid(grant_valid)
   );

   task automatic check(input string req, input logic [N-1:0] exp_g);
      n_checks++;
      if (grant !== exp_g || grant_valid !== (|exp_g)) begin
         n_fail++;
         $display("FAIL %s: grant=%b valid=%b expected grant=%b valid=%b",
                  req, grant, grant_valid, exp_g, |exp_g);
      end
   endtask

   task automatic slot(input logic [N-1:0] ne, input logic [N-1:0] hi,
                       input logic [N-1:0] exp_g, input string req);
      @(negedge clk);
      q_nonempty = ne;
      q_head_hi  = hi;
      #1;
      check(req, exp_g);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      #1;
      check("R9 reset idle", 4'b0000);
      rst_n = 1'b1;
      for (int r = 0; r < N_ROWS; r++)
         slot(VEC[r][11:8], VEC[r][7:4], VEC[r][3:0], $sformatf("R6/R7 table row %0d", r));

      // R8: background pointer left at 3 after row 8? it advanced to 0 after row 10
      slot(4'b1111, 4'b1111, 4'b1000, "R6 urgent continues from 3");
      slot(4'b1111, 4'b0000, 4'b0001, "R8 background pointer held at 0");
      slot(4'b0000, 4'b1111, 4'b0000, "R3 all urgent bits with empty queues");
      slot(4'b1111, 4'b0000, 4'b0010, "R8 no-grant cycle kept pointer");

      // R9: reset in mid-run returns both pointers to 0
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      slot(4'b1111, 4'b1111, 4'b0001, "R9 urgent pointer after reset");
      slot(4'b1110, 4'b0000, 4'b0010, "R9 background lowest eligible after reset");
      slot(4'b0101, 4'b0100, 4'b0100, "R4 R5 urgent beats lower background");

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: run did not complete, expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end
endmodule